// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This unit sits on a processor's memory path and checks each bus access against a table of eight programmable protection regions. It does not translate addresses. The address of an access comes out unchanged, and the unit decides only whether the access may go ahead and which cache attributes apply to it. Each region is a power-of-two window aligned to its own size, anywhere from 4 KB to the whole 4 GB space. A region holds an enable bit, a two-bit permission code, a cacheable bit and a bufferable bit. When regions overlap, the region with the higher number wins.

The decision is registered and appears one cycle after the request. An access that breaks its region's permissions, or that hits no enabled region, is reported as a fault. The first such fault is held in status registers (address, read/write, privilege) and raises a pending flag that a supervisor-level handler can service. The handler clears the flag with a clear strobe. Regions are programmed through a single-cycle write port.

Top module: `regionProtUnit`

## Requirements
- R1: A write on the configuration port (cfgWe high) replaces every field of region cfgIdx at the clock edge. A request presented in the same cycle as the write is judged against the table as it was before the write.
- R2: One cycle after reqValid is sampled high, rspValid is high and rspAddr equals the request address. When reqValid is low, rspValid, rspAllow, rspFault, rspCacheable and rspBufferable are low the next cycle, and rspAddr holds its value.
- R3: Region i matches an address when it is enabled and the address agrees with the region base in all bits at positions sizeLog and above. Base bits below sizeLog are ignored. A programmed sizeLog below 12 is treated as 12, and one above 32 is treated as 32; sizeLog 32 matches every address.
- R4: When several enabled regions match, only the highest-numbered one decides the permission and the attributes.
- R5: Permission codes are 0 = no access, 1 = privileged read/write only, 2 = privileged read/write with user read-only, 3 = full access. reqPriv high means privileged. A permitted access gives rspAllow=1 and rspFault=0; otherwise rspAllow=0 and rspFault=1.
- R6: An access that matches no enabled region faults.
- R7: On an allowed access, rspCacheable and rspBufferable are the winning region's bits. On a faulting access, both are 0.
- R8: A faulting access while no fault is pending sets faultPending and captures its address, write flag and privilege flag. These stay unchanged, through any later faults, until statusClr.
- R9: statusClr clears faultPending at the next edge. If a faulting access arrives in the same cycle as statusClr, that fault is captured instead and faultPending stays set.
- R10: After reset, all regions are disabled and all response and status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Region write strobe |
| cfgIdx | input | 3 | Region number to write |
| cfgEn | input | 1 | Region enable |
| cfgBase | input | 32 | Region base address |
| cfgSizeLog | input | 6 | log2 of region size in bytes |
| cfgPerm | input | 2 | Permission code |
| cfgCacheable | input | 1 | Cacheable attribute |
| cfgBufferable | input | 1 | Bufferable attribute |
| reqValid | input | 1 | Access request valid |
| reqAddr | input | 32 | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPriv | input | 1 | 1 = privileged, 0 = user |
| statusClr | input | 1 | Clear pending fault |
| rspValid | output | 1 | Decision valid |
| rspAddr | output | 32 | Untranslated access address |
| rspAllow | output | 1 | Access permitted |
| rspFault | output | 1 | Access faulted |
| rspCacheable | output | 1 | Cacheable attribute for the access |
| rspBufferable | output | 1 | Bufferable attribute for the access |
| faultPending | output | 1 | A captured fault awaits the handler |
| faultAddr | output | 32 | Address of the captured fault |
| faultWrite | output | 1 | Captured fault was a write |
| faultPriv | output | 1 | Captured fault was privileged |

## Verification
The assertions assume that the inputs are at their known idle values during reset and that every request field is stable for the whole cycle in which reqValid is sampled. The assertions make no assumption about how regions are programmed, so overlapping, misaligned and out-of-range sizes are all legal. The stimulus changes inputs only on the falling clock edge and holds every request and configuration field to a defined value in every cycle. Its random phase draws sizes beyond both clamp limits, unaligned bases and clear strobes that coincide with faults, which exercises the clamp, alignment and clear-versus-capture corners.

// File: rtl/protPkg.sv
package protPkg;

  typedef enum logic [1:0] {
    PERM_NONE     = 2'd0,
    PERM_PRIV     = 2'd1,
    PERM_USR_READ = 2'd2,
    PERM_FULL     = 2'd3
  } perm_e;

  typedef struct packed {
    logic rspLoad;
    logic captureFault;
    logic clearFault;
  } strobe_t;

endpackage

// File: rtl/protCtrl.sv
module protCtrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             decFault,
  input  logic             statusClr,
  input  logic             faultPending,
  output protPkg::strobe_t strobes
);

  always_comb begin
    strobes.rspLoad      = reqValid;
    strobes.captureFault = reqValid && decFault && (!faultPending || statusClr);
    strobes.clearFault   = statusClr;
  end

  // R9: a clear without a new fault empties the pending flag
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !(reqValid && decFault)) |=> !faultPending);

  // R8: a fault with nothing pending sets the flag
  p_fault_sets_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && decFault) |=> faultPending);

endmodule

// File: rtl/protDatapath.sv
module protDatapath #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MIN_LOG     = 12,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int SIZE_W     = $clog2(ADDR_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic                cfgEn,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [SIZE_W-1:0]   cfgSizeLog,
  input  logic [1:0]          cfgPerm,
  input  logic                cfgCacheable,
  input  logic                cfgBufferable,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqPriv,
  input  protPkg::strobe_t    strobes,
  output logic                decFault,
  output logic                rspValid,
  output logic [ADDR_W-1:0]   rspAddr,
  output logic                rspAllow,
  output logic                rspFault,
  output logic                rspCacheable,
  output logic                rspBufferable,
  output logic                faultPending,
  output logic [ADDR_W-1:0]   faultAddr,
  output logic                faultWrite,
  output logic                faultPriv
);
  import protPkg::*;

  logic [NUM_REGIONS-1:0] regEn, regCache, regBuf, hitVec;
  logic [ADDR_W-1:0]      regBase [NUM_REGIONS];
  logic [SIZE_W-1:0]      regSize [NUM_REGIONS];
  perm_e                  regPerm [NUM_REGIONS];
  logic [SIZE_W-1:0]      sizeClamped;
  logic [IDX_W-1:0]       winIdx;
  logic                   anyHit, permOk, decAllow;

  // size clamped once at write time
  always_comb begin
    if (cfgSizeLog < SIZE_W'(MIN_LOG))     sizeClamped = SIZE_W'(MIN_LOG);
    else if (cfgSizeLog > SIZE_W'(ADDR_W)) sizeClamped = SIZE_W'(ADDR_W);
    else                                   sizeClamped = cfgSizeLog;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regEn    <= '0;
      regCache <= '0;
      regBuf   <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        regBase[i] <= '0;
        regSize[i] <= SIZE_W'(MIN_LOG);
        regPerm[i] <= PERM_NONE;
      end
    end else if (cfgWe) begin
      regEn[cfgIdx]    <= cfgEn;
      regCache[cfgIdx] <= cfgCacheable;
      regBuf[cfgIdx]   <= cfgBufferable;
      regBase[cfgIdx]  <= cfgBase;
      regSize[cfgIdx]  <= sizeClamped;
      regPerm[cfgIdx]  <= perm_e'(cfgPerm);
    end
  end

  // masked compare of the bits above the region size
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    logic [ADDR_W-1:0] keepMask;
    assign keepMask  = {ADDR_W{1'b1}} << regSize[g];
    assign hitVec[g] = regEn[g] && (((reqAddr ^ regBase[g]) & keepMask) == '0);
  end

  // highest-numbered hit wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    unique case (regPerm[winIdx])
      PERM_NONE:     permOk = 1'b0;
      PERM_PRIV:     permOk = reqPriv;
      PERM_USR_READ: permOk = reqPriv || !reqWrite;
      default:       permOk = 1'b1;
    endcase
    decAllow = anyHit && permOk;
    decFault = !decAllow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspAddr       <= '0;
      rspAllow      <= 1'b0;
      rspFault      <= 1'b0;
      rspCacheable  <= 1'b0;
      rspBufferable <= 1'b0;
    end else if (strobes.rspLoad) begin
      rspValid      <= 1'b1;
      rspAddr       <= reqAddr;
      rspAllow      <= decAllow;
      rspFault      <= decFault;
      rspCacheable  <= decAllow && regCache[winIdx];
      rspBufferable <= decAllow && regBuf[winIdx];
    end else begin
      rspValid      <= 1'b0;
      rspAllow      <= 1'b0;
      rspFault      <= 1'b0;
      rspCacheable  <= 1'b0;
      rspBufferable <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultPending <= 1'b0;
      faultAddr    <= '0;
      faultWrite   <= 1'b0;
      faultPriv    <= 1'b0;
    end else if (strobes.captureFault) begin
      faultPending <= 1'b1;
      faultAddr    <= reqAddr;
      faultWrite   <= reqWrite;
      faultPriv    <= reqPriv;
    end else if (strobes.clearFault) begin
      faultPending <= 1'b0;
    end
  end

  // R2: address passes through untouched one cycle later
  p_addr_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid && rspAddr == $past(reqAddr)));

  // R5: allow and fault are exclusive and present only with a valid response
  p_allow_xor_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid ? (rspAllow != rspFault) : !(rspAllow || rspFault));

  // R7: a faulted access carries no cache attributes
  p_fault_no_attr_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> !(rspCacheable || rspBufferable));

  // R8: captured fault is held until cleared
  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultPending && !statusClrSeen()) |=> (faultPending && faultAddr == $past(faultAddr)));

  function automatic logic statusClrSeen();
    return strobes.clearFault;
  endfunction

endmodule

// File: rtl/regionProtUnit.sv
module regionProtUnit #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MIN_LOG     = 12,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int SIZE_W     = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEn,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [SIZE_W-1:0] cfgSizeLog,
  input  logic [1:0]        cfgPerm,
  input  logic              cfgCacheable,
  input  logic              cfgBufferable,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic              statusClr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspAllow,
  output logic              rspFault,
  output logic              rspCacheable,
  output logic              rspBufferable,
  output logic              faultPending,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultWrite,
  output logic              faultPriv
);

  protPkg::strobe_t strobes;
  logic             decFault;

  protCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .decFault     (decFault),
    .statusClr    (statusClr),
    .faultPending (faultPending),
    .strobes      (strobes)
  );

  protDatapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W),
    .MIN_LOG     (MIN_LOG)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .cfgWe         (cfgWe),
    .cfgIdx        (cfgIdx),
    .cfgEn         (cfgEn),
    .cfgBase       (cfgBase),
    .cfgSizeLog    (cfgSizeLog),
    .cfgPerm       (cfgPerm),
    .cfgCacheable  (cfgCacheable),
    .cfgBufferable (cfgBufferable),
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .reqWrite      (reqWrite),
    .reqPriv       (reqPriv),
    .strobes       (strobes),
    .decFault      (decFault),
    .rspValid      (rspValid),
    .rspAddr       (rspAddr),
    .rspAllow      (rspAllow),
    .rspFault      (rspFault),
    .rspCacheable  (rspCacheable),
    .rspBufferable (rspBufferable),
    .faultPending  (faultPending),
    .faultAddr     (faultAddr),
    .faultWrite    (faultWrite),
    .faultPriv     (faultPriv)
  );

endmodule

// File: tb/test_regionProtUnit.sv
module test_regionProtUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 0, cfgEn = 0, cfgCacheable = 0, cfgBufferable = 0;
  logic [2:0]  cfgIdx = 0;
  logic [31:0] cfgBase = 0;
  logic [5:0]  cfgSizeLog = 0;
  logic [1:0]  cfgPerm = 0;
  logic        reqValid = 0, reqWrite = 0, reqPriv = 0, statusClr = 0;
  logic [31:0] reqAddr = 0;
  logic        rspValid, rspAllow, rspFault, rspCacheable, rspBufferable;
  logic [31:0] rspAddr, faultAddr;
  logic        faultPending, faultWrite, faultPriv;

  always #10 clk = ~clk;

  regionProtUnit i_regionProtUnit (.*);

  int checks = 0, errors = 0;
  string curTag = "R10";

  // behavioural model state
  bit          mEn [8];
  bit          mC [8], mB [8];
  int unsigned mSize [8];
  logic [31:0] mBase [8];
  int          mPerm [8];
  bit          eValid, eAllow, eFault, eC, eB, ePend, eFW, eFP;
  logic [31:0] eAddr, eFAddr;

  task automatic compare();
    logic [36:0] actR, expR;
    logic [34:0] actS, expS;
    actR = {rspValid, rspAllow, rspFault, rspCacheable, rspBufferable, rspAddr};
    expR = {eValid, eAllow, eFault, eC, eB, eAddr};
    actS = {faultPending, faultWrite, faultPriv, faultAddr};
    expS = {ePend, eFW, eFP, eFAddr};
    checks += 2;
    if (actR !== expR) begin
      errors++;
      $display("FAIL %s response: actual %h expected %h", curTag, actR, expR);
    end
    if (actS !== expS) begin
      errors++;
      $display("FAIL %s status: actual %h expected %h", curTag, actS, expS);
    end
  endtask

  task automatic step(input bit we, input int idx, input bit en, input logic [31:0] base,
                      input int sz, input int perm, input bit c, input bit b,
                      input bit rv, input logic [31:0] a, input bit w, input bit p, input bit clr);
    bit ok, hit;
    int win;
    @(negedge clk);
    compare();
    cfgWe = we; cfgIdx = 3'(idx); cfgEn = en; cfgBase = base; cfgSizeLog = 6'(sz);
    cfgPerm = 2'(perm); cfgCacheable = c; cfgBufferable = b;
    reqValid = rv; reqAddr = a; reqWrite = w; reqPriv = p; statusClr = clr;
    // decision against table before this cycle's write
    hit = 0; win = 0;
    for (int i = 0; i < 8; i++) begin
      longint unsigned span = 64'd1 << mSize[i];
      if (mEn[i] && (longint'(a) / span == longint'(mBase[i]) / span)) begin hit = 1; win = i; end
    end
    ok = 0;
    if (hit) case (mPerm[win])
      0: ok = 0;
      1: ok = p;
      2: ok = p || !w;
      default: ok = 1;
    endcase
    eValid = rv; eAllow = rv && ok; eFault = rv && !ok;
    eC = rv && ok && mC[win]; eB = rv && ok && mB[win];
    if (rv) eAddr = a;
    if (rv && !ok && (!ePend || clr)) begin ePend = 1; eFAddr = a; eFW = w; eFP = p; end
    else if (clr) ePend = 0;
    if (we) begin
      mEn[idx] = en; mBase[idx] = base; mPerm[idx] = perm; mC[idx] = c; mB[idx] = b;
      mSize[idx] = (sz < 12) ? 12 : (sz > 32) ? 32 : sz;
    end
  endtask

  task automatic prog(input int idx, input bit en, input logic [31:0] base, input int sz,
                      input int perm, input bit c, input bit b);
    step(1, idx, en, base, sz, perm, c, b, 0, 0, 0, 0, 0);
  endtask

  task automatic acc(input logic [31:0] a, input bit w, input bit p);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, a, w, p, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mEn[i] = 0; mC[i] = 0; mB[i] = 0; mSize[i] = 12; mBase[i] = 0; mPerm[i] = 0;
    end
    {eValid, eAllow, eFault, eC, eB, ePend, eFW, eFP} = '0;
    eAddr = 0; eFAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curTag = "R10";                          // reset state, empty table faults
    idle();
    acc(32'h1234_5678, 0, 1);
    curTag = "R6";
    acc(32'h0000_0040, 1, 0);                // no region: fault, status kept from first
    curTag = "R1";                           // write and request in same cycle: old table
    step(1, 0, 1, 32'h0, 32, 3, 0, 1, 1, 32'h0000_1000, 0, 0, 0);
    acc(32'h0000_1000, 0, 0);                // now allowed, c0 b1
    curTag = "R5";
    prog(1, 1, 32'h2000_0000, 16, 2, 1, 1);
    acc(32'h2000_1234, 1, 0);                // user write to user-read: fault
    acc(32'h2000_1234, 0, 0);                // user read: allow c1 b1
    acc(32'h2000_1234, 1, 1);                // privileged write: allow
    curTag = "R4";
    prog(7, 1, 32'h2000_0000, 12, 0, 1, 1);  // top region, no access
    acc(32'h2000_0abc, 0, 1);                // region 7 wins: fault
    acc(32'h2000_1abc, 0, 1);                // outside region 7: region 1
    curTag = "R3";
    prog(2, 1, 32'h4000_0123, 13, 1, 1, 0);  // low base bits ignored
    acc(32'h4000_1ff0, 1, 1);
    acc(32'h4000_2000, 1, 0);                // falls to region 0
    acc(32'h4000_0010, 0, 0);                // user in privileged region: fault
    prog(3, 1, 32'h6000_0000, 3, 1, 0, 0);   // size clamps up to 4 KB
    acc(32'h6000_0fff, 0, 0);
    acc(32'h6000_1000, 0, 0);
    prog(4, 1, 32'h0, 40, 3, 1, 0);          // size clamps down to whole space
    acc(32'hFFFF_FFF0, 0, 0);
    prog(4, 0, 32'h0, 12, 0, 0, 0);
    curTag = "R7";
    acc(32'h2000_8000, 0, 0);                // allowed attrs c1 b1
    acc(32'h2000_0000, 0, 1);                // fault: attrs 0
    curTag = "R2";
    idle();                                  // address holds, flags low
    acc(32'hABCD_0000, 1, 1);
    curTag = "R6";
    prog(0, 0, 32'h0, 32, 3, 0, 0);
    acc(32'h8000_0000, 0, 1);
    curTag = "R8";
    acc(32'h9000_0000, 1, 0);                // status still holds the first fault
    idle();
    curTag = "R9";
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hA000_0004, 1, 1, 1); // clear with fault: new capture
    idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);             // plain clear
    idle();
    curTag = "R8";
    acc(32'hB000_0008, 0, 0);
    idle();
    curTag = "R4";                           // random mix, every clock compared
    for (int n = 0; n < 2000; n++) begin
      bit we = ($urandom_range(0, 7) == 0);
      logic [31:0] a = {$urandom_range(0, 3) == 0 ? 4'h2 : 4'($urandom), 28'($urandom)};
      step(we, $urandom_range(0, 7), 1'($urandom), {4'($urandom), 28'($urandom)},
           $urandom_range(0, 40), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
           1'($urandom), a, 1'($urandom), 1'($urandom), $urandom_range(0, 5) == 0);
    end
    @(negedge clk);
    compare();
    finishRun();
  end

endmodule